// File: doc/BRIEF.md
# Zero-Dominant Four-Lane Float Multiplier

This block multiplies two packed vectors of four 24-bit floating-point values, one lane per component (X, Y, Z, W). It behaves like an ordinary truncating float multiplier except for one rule. When either operand is zero and neither operand is NaN, the lane produces positive zero. This holds even when the other operand is infinite, so zero times infinity gives zero and not NaN. A NaN on either side still wins and yields NaN. A shader-style vector unit uses the same sanitized product as the first step of its multiply-add and dot-product paths.

Each lane sorts both operands into one of four kinds: ZERO, NORM, INF or NANV. It then picks one result selector: SEL_NAN, SEL_ZERO, SEL_INF, SEL_UNDER, SEL_OVER or SEL_FIN. A `unique case` on the selector builds the result word. The transitions run in priority order. Any NANV operand moves to SEL_NAN. Otherwise any ZERO operand moves to SEL_ZERO. Otherwise any INF operand moves to SEL_INF. For two NORM operands, the exponent sum moves to SEL_UNDER, SEL_OVER or SEL_FIN. A 4-bit write mask merges the products into a caller-supplied old destination vector. One pipeline register holds both the product vector and the merged destination.

Top module: `vfm_top`

## Requirements
- R1: When one operand of a lane is zero and the other is not NaN, the lane product is +0 (all bits clear), including when the other operand is ±infinity.
- R2: When either operand of a lane is NaN (exponent all ones, mantissa non-zero), the lane product is the canonical NaN 0x7F8000, even when the other operand is zero.
- R3: Lane i occupies bits [24i+23:24i], with lane 0 = X. Each value is sign bit 23, exponent bits 22:16 (bias 63) and mantissa bits 15:0 with a hidden leading one. A product of two normal numbers carries the XOR of the signs, and its mantissa is truncated toward zero.
- R4: An operand with exponent 0 is treated as zero whatever its mantissa (denormals flush), so R1 applies to it.
- R5: Infinity (exponent 0x7F, mantissa 0) times a non-zero, non-NaN operand gives infinity with the XOR of the signs. A normal product whose biased exponent reaches 127 or more saturates to that signed infinity.
- R6: A normal product whose biased exponent is 0 or less flushes to a zero that keeps the XOR of the signs.
- R7: For each lane i, out_dst lane i equals the product when in_mask[i] is 1, and equals dst_old lane i otherwise.
- R8: out_valid equals in_valid from the previous clock. A new vector is accepted every cycle.
- R9: While in_valid is low, out_prod and out_dst keep their values.
- R10: After reset, out_valid, out_prod and out_dst are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input vector strobe |
| in_mask | input | 4 | Destination write mask, bit i for lane i |
| src_a | input | 96 | First operand vector |
| src_b | input | 96 | Second operand vector |
| dst_old | input | 96 | Current destination vector |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_prod | output | 96 | Registered product vector |
| out_dst | output | 96 | Registered merged destination |

## Verification
The timing assertions assume that in_valid is held low while reset is asserted. Otherwise the first cycle after release would see a valid strobe that the reset discarded. The bench drives in_valid low throughout reset and changes inputs only on falling edges. The value assertions take any operand bits, so the stimulus sweeps every pairing of signed zeros, denormals, infinities, NaNs and normals at the extremes of range. It also sweeps all 128 exponents of one operand against exponents near the bias, to reach both the underflow and the overflow boundary.

// File: rtl/vfm_pkg.sv
package vfm_pkg;

    // Operand classification
    typedef enum logic [1:0] {
        K_ZERO = 2'd0,
        K_NORM = 2'd1,
        K_INF  = 2'd2,
        K_NANV = 2'd3
    } vfm_kind_e;

    // Result selection, in priority order of the lane decision
    typedef enum logic [2:0] {
        SEL_NAN   = 3'd0,
        SEL_ZERO  = 3'd1,
        SEL_INF   = 3'd2,
        SEL_UNDER = 3'd3,
        SEL_OVER  = 3'd4,
        SEL_FIN   = 3'd5
    } vfm_sel_e;

endpackage

// File: rtl/vfm_classify.sv
module vfm_classify
    import vfm_pkg::*;
#(
    parameter int EXP_W = 7,
    parameter int MAN_W = 16
) (
    input  logic [EXP_W-1:0] exp_f,
    input  logic [MAN_W-1:0] man_f,
    output vfm_kind_e        kind
);

    always_comb begin
        unique case ({&exp_f, |exp_f})
            2'b11:   kind = (|man_f) ? K_NANV : K_INF;
            2'b01:   kind = K_NORM;
            2'b00:   kind = K_ZERO;   // denormals flush to zero
            default: kind = K_ZERO;
        endcase
    end

endmodule

// File: rtl/vfm_lane.sv
module vfm_lane
    import vfm_pkg::*;
#(
    parameter int EXP_W = 7,
    parameter int MAN_W = 16,
    localparam int W    = 1 + EXP_W + MAN_W
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic [W-1:0] prod,
    output vfm_kind_e    kind_a,
    output vfm_kind_e    kind_b
);

    localparam int EXP_MAX = (1 << EXP_W) - 1;
    localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
    localparam int SUM_W   = EXP_W + 2;
    localparam int PM_W    = 2 * MAN_W + 2;

    vfm_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls_a (
        .exp_f (op_a[W-2:MAN_W]),
        .man_f (op_a[MAN_W-1:0]),
        .kind  (kind_a)
    );

    vfm_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls_b (
        .exp_f (op_b[W-2:MAN_W]),
        .man_f (op_b[MAN_W-1:0]),
        .kind  (kind_b)
    );

    logic              sgn;
    logic [MAN_W:0]    sig_a;
    logic [MAN_W:0]    sig_b;
    logic [PM_W-1:0]   full;
    logic              norm;
    logic [PM_W-1:0]   full_n;
    logic [MAN_W-1:0]  frac;
    logic [SUM_W-1:0]  exp_sum;
    logic [EXP_W-1:0]  exp_res;
    logic              under;
    logic              over;
    vfm_sel_e          sel;

    assign sgn     = op_a[W-1] ^ op_b[W-1];
    assign sig_a   = {1'b1, op_a[MAN_W-1:0]};
    assign sig_b   = {1'b1, op_b[MAN_W-1:0]};
    assign full    = PM_W'(sig_a) * PM_W'(sig_b);
    assign norm    = full[PM_W-1];
    assign full_n  = norm ? (full >> 1) : full;
    assign frac    = MAN_W'(full_n >> MAN_W);          // truncation
    assign exp_sum = SUM_W'(op_a[W-2:MAN_W]) + SUM_W'(op_b[W-2:MAN_W]) + SUM_W'(norm);
    assign under   = exp_sum <= SUM_W'(BIAS);
    assign over    = exp_sum >= SUM_W'(BIAS + EXP_MAX);
    assign exp_res = EXP_W'(exp_sum - SUM_W'(BIAS));

    // Selector decision: NaN beats zero, zero beats infinity
    always_comb begin
        if (kind_a == K_NANV || kind_b == K_NANV)
            sel = SEL_NAN;
        else if (kind_a == K_ZERO || kind_b == K_ZERO)
            sel = SEL_ZERO;
        else if (kind_a == K_INF || kind_b == K_INF)
            sel = SEL_INF;
        else if (under)
            sel = SEL_UNDER;
        else if (over)
            sel = SEL_OVER;
        else
            sel = SEL_FIN;
    end

    // Result word per selector
    always_comb begin
        unique case (sel)
            SEL_NAN:   prod = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};
            SEL_ZERO:  prod = '0;
            SEL_INF:   prod = {sgn, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
            SEL_UNDER: prod = {sgn, {(W-1){1'b0}}};
            SEL_OVER:  prod = {sgn, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
            SEL_FIN:   prod = {sgn, exp_res, frac};
            default:   prod = '0;
        endcase
    end

endmodule

// File: rtl/vfm_top.sv
module vfm_top
    import vfm_pkg::*;
#(
    parameter int EXP_W = 7,
    parameter int MAN_W = 16,
    parameter int LANES = 4,
    localparam int W    = 1 + EXP_W + MAN_W,
    localparam int VW   = LANES * W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [LANES-1:0] in_mask,
    input  logic [VW-1:0]    src_a,
    input  logic [VW-1:0]    src_b,
    input  logic [VW-1:0]    dst_old,
    output logic             out_valid,
    output logic [VW-1:0]    out_prod,
    output logic [VW-1:0]    out_dst
);

    logic [VW-1:0]  prod_c;
    logic [VW-1:0]  merge_c;
    vfm_kind_e      kind_a [LANES];
    vfm_kind_e      kind_b [LANES];

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        vfm_lane #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_lane (
            .op_a   (src_a[i*W +: W]),
            .op_b   (src_b[i*W +: W]),
            .prod   (prod_c[i*W +: W]),
            .kind_a (kind_a[i]),
            .kind_b (kind_b[i])
        );

        assign merge_c[i*W +: W] = in_mask[i] ? prod_c[i*W +: W] : dst_old[i*W +: W];

        AST_ZERO_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid && ((kind_a[i] == K_ZERO && kind_b[i] != K_NANV) ||
                         (kind_b[i] == K_ZERO && kind_a[i] != K_NANV))
            |=> out_prod[i*W +: W] == '0); // R1

        AST_NAN_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid && (kind_a[i] == K_NANV || kind_b[i] == K_NANV)
            |=> (&out_prod[i*W+MAN_W +: EXP_W]) && (|out_prod[i*W +: MAN_W])); // R2

        AST_MASK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid && !in_mask[i]
            |=> out_dst[i*W +: W] == $past(dst_old[i*W +: W])); // R7

        AST_MASK_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid && in_mask[i]
            |=> out_dst[i*W +: W] == out_prod[i*W +: W]); // R7
    end

    // Single pipeline register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_prod  <= '0;
            out_dst   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_prod <= prod_c;
                out_dst  <= merge_c;
            end
        end
    end

    AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R8

    AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_prod) && $stable(out_dst)); // R9

endmodule

// File: tb/tb_vfm_top.sv
module tb_vfm_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  in_mask = '0;
    logic [95:0] src_a = '0;
    logic [95:0] src_b = '0;
    logic [95:0] dst_old = '0;
    logic        out_valid;
    logic [95:0] out_prod;
    logic [95:0] out_dst;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    vfm_top dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mask(in_mask),
        .src_a(src_a), .src_b(src_b), .dst_old(dst_old),
        .out_valid(out_valid), .out_prod(out_prod), .out_dst(out_dst)
    );

    always #4 clk = ~clk;   // 125 MHz

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    function automatic logic [23:0] ref_mul(input logic [23:0] a, input logic [23:0] b);
        logic [6:0]  ea, eb;
        logic [15:0] ma, mb;
        logic        s;
        longint      p;
        int          e;
        logic [15:0] m;
        ea = a[22:16]; eb = b[22:16]; ma = a[15:0]; mb = b[15:0];
        s = a[23] ^ b[23];
        if ((ea == 7'h7F && ma != 0) || (eb == 7'h7F && mb != 0)) return 24'h7F8000;
        if (ea == 0 || eb == 0) return 24'h000000;
        if (ea == 7'h7F || eb == 7'h7F) return {s, 7'h7F, 16'h0000};
        p = (longint'(ma) + 65536) * (longint'(mb) + 65536);
        e = int'(ea) + int'(eb) - 63;
        if (p >= 64'h2_0000_0000) begin
            e = e + 1;
            m = 16'((p >> 17) & 64'hFFFF);
        end else begin
            m = 16'((p >> 16) & 64'hFFFF);
        end
        if (e >= 127) return {s, 7'h7F, 16'h0000};
        if (e <= 0) return {s, 23'h0};
        return {s, e[6:0], m};
    endfunction

    function automatic logic [23:0] special(input int k);
        case (k)
            0:  return 24'h000000;
            1:  return 24'h800000;
            2:  return 24'h000123;
            3:  return 24'h7F0000;
            4:  return 24'hFF0000;
            5:  return 24'h7F8000;
            6:  return 24'hFF0001;
            7:  return 24'h3F0000;
            8:  return 24'hBF0000;
            9:  return 24'h408000;
            10: return 24'h010000;
            11: return 24'h7EFFFF;
            12: return 24'h3E4000;
            13: return 24'hC1ABCD;
            14: return 24'h20FFFF;
            default: return 24'h5D1234;
        endcase
    endfunction

    function automatic string tag_of(input logic [23:0] a, input logic [23:0] b);
        logic an, bn, az, bz, ai, bi;
        an = a[22:16] == 7'h7F && a[15:0] != 0;
        bn = b[22:16] == 7'h7F && b[15:0] != 0;
        az = a[22:16] == 0; bz = b[22:16] == 0;
        ai = a[22:16] == 7'h7F && !an; bi = b[22:16] == 7'h7F && !bn;
        if (an || bn) return "R2";
        if ((az && a[15:0] != 0) || (bz && b[15:0] != 0)) return "R4";
        if (az || bz) return "R1";
        if (ai || bi) return "R5";
        return "R3/R5/R6";
    endfunction

    task automatic check(input string req, input logic [95:0] got, input logic [95:0] exp);
        n_cmp = n_cmp + 1;
        if (got !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    // Drive one vector at a falling edge; compare at the next falling edge.
    task automatic step(input logic [95:0] a, input logic [95:0] b,
                        input logic [95:0] old, input logic [3:0] mask);
        logic [95:0] ep, ed;
        for (int l = 0; l < 4; l++) begin
            ep[l*24 +: 24] = ref_mul(a[l*24 +: 24], b[l*24 +: 24]);
            ed[l*24 +: 24] = mask[l] ? ep[l*24 +: 24] : old[l*24 +: 24];
        end
        src_a = a; src_b = b; dst_old = old; in_mask = mask; in_valid = 1'b1;
        @(negedge clk);
        check("R8 valid", {95'h0, out_valid}, 96'h1);
        for (int l = 0; l < 4; l++)
            check(tag_of(a[l*24 +: 24], b[l*24 +: 24]), {72'h0, out_prod[l*24 +: 24]},
                  {72'h0, ep[l*24 +: 24]});
        check("R7 merge", out_dst, ed);
    endtask

    initial begin
        logic [95:0] a, b, old, held_p, held_d;
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 valid", {95'h0, out_valid}, 96'h0);
        check("R10 prod", out_prod, 96'h0);
        check("R10 dst", out_dst, 96'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // Every pairing of the special operand list, back to back
        for (int i = 0; i < 16; i++) begin
            for (int q = 0; q < 4; q++) begin
                for (int l = 0; l < 4; l++) begin
                    a[l*24 +: 24] = special(i);
                    b[l*24 +: 24] = special(q*4 + l);
                    old[l*24 +: 24] = 24'hA5A500 ^ 24'(i*64 + q*4 + l);
                end
                step(a, b, old, 4'(i + q));
                step(b, a, old, 4'(~(i + q)));
            end
        end

        // Exponent sweep across underflow and overflow edges (R3, R5, R6)
        for (int ea = 0; ea < 128; ea++) begin
            for (int j = 0; j < 2; j++) begin
                for (int l = 0; l < 4; l++) begin
                    int eb;
                    eb = (j == 0) ? (1 + l * 20) : (62 + l * 21);
                    a[l*24 +: 24] = {1'(ea & 1), 7'(ea), 16'(ea * 517 + l)};
                    b[l*24 +: 24] = {1'(l & 1), 7'(eb), 16'(ea * 4099 + j * 77 + l * 9001)};
                    old[l*24 +: 24] = 24'(ea * 3 + l);
                end
                step(a, b, old, 4'hF);
            end
        end

        // R9: idle cycle holds outputs, R8: valid drops
        held_p = out_prod;
        held_d = out_dst;
        in_valid = 1'b0;
        src_a = {4{24'h3F0000}};
        src_b = {4{24'h408000}};
        dst_old = '1;
        in_mask = 4'hF;
        @(negedge clk);
        check("R8 valid drop", {95'h0, out_valid}, 96'h0);
        check("R9 prod hold", out_prod, held_p);
        check("R9 dst hold", out_dst, held_d);
        @(negedge clk);
        check("R9 prod hold 2", out_prod, held_p);

        // R1 explicit: 0 x -inf gives +0, mask mixes lanes (R7)
        step({24'h000000, 24'hFF0000, 24'h800000, 24'h7F0000},
             {24'hFF0000, 24'h000000, 24'h7F0000, 24'h800000},
             {4{24'h123456}}, 4'b0101);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule